// File: doc/BRIEF.md
# Program Memory Word Fetch Controller

This block lets an 8-bit processor core pull a single 14-bit word out of its own program storage, or out of the separate configuration space. Software writes a word address into two byte registers, picks the space with a select bit in a control register, and sets a go bit. The controller then borrows the core's next instruction slot for the array access. It tells the core to turn the two instructions fetched after the go write into no-operations, and it loads the word into a pair of data registers. When those two slots have passed, software reads the result back as two bytes.

The core supplies a one-cycle strobe that marks the end of each instruction slot. The controller answers with a squash flag that stays high through exactly the two slots that follow the go write. A synchronous array model with computed contents stands in for the real storage.

Top module: `pmem_rd_ctrl`

## Requirements
- R1: After reset every register reads zero (address low/high, data low/high, control), no read is pending and squash is low.
- R2: Register offsets on reg_addr are 0 address low, 1 address high (7 bits, upper bit reads 0), 2 data low, 3 data high, 4 control. Control bit 0 is the go/busy bit and bit 6 is the space select (1 = configuration space). Other control bits and unused offsets read 0.
- R3: A write to control with bit 0 set while idle raises squash on the next clock.
- R4: Squash stays high for exactly two slot strobes after the go write and drops at the clock edge of the second one.
- R5: With select 0 the word read is (3*A + 0x155) mod 2^14, where A = {address high[6:0], address low}.
- R6: With select 1 the word read is (A XOR 0x2A3C) mod 2^14.
- R7: The word is in the data registers as soon as squash drops: bits 7:0 in data low, bits 13:8 in data high, and data high bits 7:6 always read 0.
- R8: The data registers keep their value until another read completes or software writes them. A software write to data high keeps only its low 6 bits.
- R9: The go bit clears itself when the word is latched. Writing 0 to it has no effect on a read in progress.
- R10: Any control write made while a read is pending is ignored, including a second go request and a change of the select bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe from the core |
| reg_addr | input | 3 | Register offset for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on reg_addr |
| slot_adv | input | 1 | One-cycle strobe that ends an instruction slot |
| squash | output | 1 | High while the core must execute its fetched instruction as a no-operation |

## Verification
Reads run with slot_adv held high on every clock and also with slot_adv gapped at random. This separates counting clocks from counting slots, which a squash window must do. Random addresses in both spaces, together with the all-zero and all-ones addresses, check that the two content formulas and the byte split are right, and show whether the select bit has been sampled at the access. Control writes of zero and repeated go writes arrive in the middle of a read. Together with software writes to the data pair and idle stretches, they show whether a pending read can be disturbed and whether the latched word holds.

// File: rtl/pmrc_pkg.sv
package pmrc_pkg;
  localparam int WORD_W = 14;

  localparam logic [2:0] RA_ALO  = 3'd0;
  localparam logic [2:0] RA_AHI  = 3'd1;
  localparam logic [2:0] RA_DLO  = 3'd2;
  localparam logic [2:0] RA_DHI  = 3'd3;
  localparam logic [2:0] RA_CTRL = 3'd4;

  localparam int CTL_GO  = 0;
  localparam int CTL_SEL = 6;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ACC   = 2'd1,
    SQ_LATCH = 2'd2
  } sq_state_t;

  // Computed contents of the storage model for either space.
  function automatic logic [WORD_W-1:0] word_of(input logic cfg, input logic [15:0] a);
    logic [15:0] t;
    if (cfg) t = a ^ 16'h2A3C;
    else     t = (a * 16'd3) + 16'h0155;
    return t[WORD_W-1:0];
  endfunction
endpackage

// File: rtl/pmrc_seq.sv
module pmrc_seq
  import pmrc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic slot_adv,
  output logic busy,
  output logic access_en,
  output logic done
);
  sq_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SQ_IDLE:  if (start_req) st_d = SQ_ACC;
      SQ_ACC:   if (slot_adv)  st_d = SQ_LATCH;
      SQ_LATCH: if (slot_adv)  st_d = SQ_IDLE;
      default:                 st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  assign busy      = (st_q != SQ_IDLE);
  assign access_en = (st_q == SQ_ACC) && slot_adv;
  assign done      = (st_q == SQ_LATCH) && slot_adv;
endmodule

// File: rtl/pmrc_array.sv
module pmrc_array
  import pmrc_pkg::*;
#(
  parameter int AW = 15,
  parameter int DW = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          space,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] q
);
  logic [DW-1:0] q_d;

  always_comb begin
    q_d = q;
    if (en) q_d = DW'(word_of(space, 16'(addr)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/pmrc_regs.sv
module pmrc_regs
  import pmrc_pkg::*;
#(
  parameter int AW = 15,
  parameter int DW = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  input  logic          busy,
  input  logic          done,
  input  logic [DW-1:0] mem_q,
  output logic [7:0]    reg_rdata,
  output logic          start_req,
  output logic [AW-1:0] word_addr,
  output logic          space
);
  localparam int AHW = AW - 8;
  localparam int DHW = DW - 8;

  logic [7:0]     alo_q, alo_d;
  logic [AHW-1:0] ahi_q, ahi_d;
  logic [7:0]     dlo_q, dlo_d;
  logic [DHW-1:0] dhi_q, dhi_d;
  logic           sel_q, sel_d;

  assign start_req = reg_we && (reg_addr == RA_CTRL) && reg_wdata[CTL_GO] && !busy;

  always_comb begin
    alo_d = alo_q;
    ahi_d = ahi_q;
    dlo_d = dlo_q;
    dhi_d = dhi_q;
    sel_d = sel_q;
    if (reg_we) begin
      case (reg_addr)
        RA_ALO:  alo_d = reg_wdata;
        RA_AHI:  ahi_d = reg_wdata[AHW-1:0];
        RA_DLO:  dlo_d = reg_wdata;
        RA_DHI:  dhi_d = reg_wdata[DHW-1:0];
        RA_CTRL: if (!busy) sel_d = reg_wdata[CTL_SEL];
        default: ;
      endcase
    end
    if (done) begin
      dlo_d = mem_q[7:0];
      dhi_d = mem_q[DW-1:8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alo_q <= '0;
      ahi_q <= '0;
      dlo_q <= '0;
      dhi_q <= '0;
      sel_q <= 1'b0;
    end else begin
      alo_q <= alo_d;
      ahi_q <= ahi_d;
      dlo_q <= dlo_d;
      dhi_q <= dhi_d;
      sel_q <= sel_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_ALO:  reg_rdata = alo_q;
      RA_AHI:  reg_rdata[AHW-1:0] = ahi_q;
      RA_DLO:  reg_rdata = dlo_q;
      RA_DHI:  reg_rdata[DHW-1:0] = dhi_q;
      RA_CTRL: begin
        reg_rdata[CTL_GO]  = busy;
        reg_rdata[CTL_SEL] = sel_q;
      end
      default: ;
    endcase
  end

  assign word_addr = {ahi_q, alo_q};
  assign space     = sel_q;
endmodule

// File: rtl/pmem_rd_ctrl.sv
module pmem_rd_ctrl
  import pmrc_pkg::*;
#(
  parameter int AW = 15,
  parameter int DW = WORD_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       slot_adv,
  output logic       squash
);
  logic [1:0]    rst_sync;
  logic          rst_s;
  logic          start_req, busy, access_en, rd_done, space;
  logic [AW-1:0] word_addr;
  logic [DW-1:0] mem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  pmrc_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_s),
    .start_req (start_req),
    .slot_adv  (slot_adv),
    .busy      (busy),
    .access_en (access_en),
    .done      (rd_done)
  );

  pmrc_array #(.AW(AW), .DW(DW)) u_array (
    .clk   (clk),
    .rst_n (rst_s),
    .en    (access_en),
    .space (space),
    .addr  (word_addr),
    .q     (mem_q)
  );

  pmrc_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_s),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .busy      (busy),
    .done      (rd_done),
    .mem_q     (mem_q),
    .reg_rdata (reg_rdata),
    .start_req (start_req),
    .word_addr (word_addr),
    .space     (space)
  );

  assign squash = busy;
endmodule

// File: rtl/pmrc_chk.sv
module pmrc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [2:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       slot_adv,
  input logic       squash,
  input logic       rd_done,
  input logic [7:0] dat_lo,
  input logic [5:0] dat_hi
);
  logic [1:0] sq_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sq_cnt <= 2'd0;
    else if (!squash)  sq_cnt <= 2'd0;
    else if (slot_adv) sq_cnt <= sq_cnt + 2'd1;
  end

  AST_START_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd4 && reg_wdata[0] && !squash) |=> squash); // R3

  AST_SQUASH_TWO_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(squash) |-> ($past(sq_cnt) == 2'd1 && $past(slot_adv))); // R4

  AST_SQUASH_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    sq_cnt != 2'd3); // R4

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(reg_we && (reg_addr == 3'd2 || reg_addr == 3'd3)) && !rd_done)
      |=> ($stable(dat_lo) && $stable(dat_hi))); // R8

  AST_HI_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd3) |-> (reg_rdata[7:6] == 2'b00)); // R7

  AST_GO_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !squash); // R9
endmodule

bind pmem_rd_ctrl pmrc_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_s),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .slot_adv  (slot_adv),
  .squash    (squash),
  .rd_done   (rd_done),
  .dat_lo    (u_regs.dlo_q),
  .dat_hi    (u_regs.dhi_q)
);

// File: tb/pmem_rd_ctrl_tb_top.sv
`timescale 1ns/1ps
module pmem_rd_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_we;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       slot_adv;
  logic       squash;

  int checks = 0;
  int errors = 0;
  int sq_cnt = 0;
  bit slot_rand = 1'b0;

  always #5 clk = ~clk;

  pmem_rd_ctrl dut_i (
    .clk (clk), .rst_n (rst_n), .reg_we (reg_we), .reg_addr (reg_addr),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .slot_adv (slot_adv),
    .squash (squash)
  );

  initial begin
    slot_adv = 1'b1;
    forever begin
      @(posedge clk);
      #2;
      slot_adv = slot_rand ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  always @(negedge clk) if (squash && slot_adv) sq_cnt++;

  function automatic int exp_word(input bit cfg, input int a);
    if (cfg) return (a ^ 'h2A3C) & 'h3FFF;
    return (3 * a + 'h155) % 16384;
  endfunction

  task automatic tick;
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    tick;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    reg_addr = a;
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic wait_idle;
    int n = 0;
    while (squash && n < 300) begin tick; n++; end
  endtask

  task automatic check_data(input bit cfg, input int a);
    int v, w;
    w = exp_word(cfg, a);
    rd(3'd2, v); chk(v == (w & 'hFF), cfg ? "R6 data low" : "R5 data low", v, w & 'hFF);
    rd(3'd3, v); chk(v == (w >> 8), "R7 data high", v, w >> 8);
  endtask

  // Starts a read, optionally disturbs it with a control write, then checks it.
  task automatic run_read(input int a, input bit cfg, input int disturb, input logic [7:0] dval);
    int base, v;
    wr(3'd0, 8'(a));
    wr(3'd1, 8'(a >> 8));
    base = sq_cnt;
    wr(3'd4, {1'b0, cfg, 5'b0, 1'b1});
    chk(squash == 1'b1, "R3 squash after go", int'(squash), 1);
    if (disturb != 0) wr(3'd4, dval);
    wait_idle;
    chk(sq_cnt - base == 2, "R4 squashed slots", sq_cnt - base, 2);
    check_data(cfg, a);
    rd(3'd4, v);
    chk(v == (cfg ? 'h40 : 0), "R9 go cleared, select kept", v, cfg ? 'h40 : 0);
  endtask

  initial begin
    int v, a, base;
    void'($urandom(32'd7741));
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 3'd0; reg_wdata = 8'd0;
    repeat (3) tick;
    rst_n = 1'b1;
    repeat (4) tick;

    for (int i = 0; i < 5; i++) begin
      rd(3'(i), v);
      chk(v == 0, "R1 reset register", v, 0);
    end
    chk(squash == 1'b0, "R1 reset squash", int'(squash), 0);

    wr(3'd0, 8'hA5); rd(3'd0, v); chk(v == 'hA5, "R2 address low", v, 'hA5);
    wr(3'd1, 8'hFF); rd(3'd1, v); chk(v == 'h7F, "R2 address high width", v, 'h7F);
    wr(3'd4, 8'hFE); rd(3'd4, v); chk(v == 'h40, "R2 control bits", v, 'h40);
    chk(squash == 1'b0, "R2 no go without bit 0", int'(squash), 0);
    rd(3'd6, v); chk(v == 0, "R2 unused offset", v, 0);
    wr(3'd4, 8'h00);

    run_read(0, 1'b0, 0, 8'h00);
    run_read('h7FFF, 1'b0, 0, 8'h00);
    run_read(0, 1'b1, 0, 8'h00);
    run_read('h7FFF, 1'b1, 0, 8'h00);

    repeat (10) tick;
    check_data(1'b1, 'h7FFF);
    wr(3'd2, 8'h3C); rd(3'd2, v); chk(v == 'h3C, "R8 software write low", v, 'h3C);
    wr(3'd3, 8'hFF); rd(3'd3, v); chk(v == 'h3F, "R8 software write high", v, 'h3F);

    // R9: writing zero mid-read; R10: select change mid-read ignored
    run_read('h1234, 1'b1, 1, 8'h00);
    wr(3'd4, 8'h00);
    // R10: second go mid-read
    run_read('h0ABC, 1'b0, 1, 8'h41);
    base = sq_cnt;
    repeat (8) tick;
    chk(squash == 1'b0 && sq_cnt == base, "R10 no second read", sq_cnt - base, 0);
    check_data(1'b0, 'h0ABC);

    slot_rand = 1'b1;
    for (int i = 0; i < 30; i++) begin
      a = int'($urandom % 32768);
      run_read(a, 1'($urandom % 2), 0, 8'h00);
      wr(3'd4, 8'h00);
    end
    slot_rand = 1'b0;
    for (int i = 0; i < 10; i++) begin
      a = int'($urandom % 32768);
      run_read(a, 1'($urandom % 2), 0, 8'h00);
      wr(3'd4, 8'h00);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule